// File: doc/BRIEF.md
# Packed Small-Float Colour Unpacker

This block turns one 32-bit packed pixel word into three IEEE single-precision channel values (red, green, blue). It reads two unsigned packed layouts. In the packed colour layout, red and green are each an 11-bit float and blue is a 10-bit float. Each of these floats has a 5-bit biased exponent and no sign bit. In the shared-exponent layout, three 9-bit fractions share one 5-bit exponent and have an implied leading zero.

A mode bit picks the layout for each word, and a valid strobe travels with the word. Each conversion is exact and sits behind one register stage. Conversions can be issued back to back on every cycle. When no word is offered, the output registers keep their last values.

Top module: `pkfloat_unpack`

## Requirements
- R1: With `in_mode` = 0 (packed colour), red is decoded from bits 10:0, green from bits 21:11 and blue from bits 31:22. Inside each channel the exponent is the top 5 bits and the fraction is the rest: 6 bits for red and green, 5 bits for blue.
- R2: A packed-colour channel with exponent e in 1..30 and an F-bit fraction f gives exactly (1 + f/2^F) × 2^(e−15). This covers the largest finite values, 65024 for red and green and 64512 for blue.
- R3: A packed-colour channel with exponent 0 and a nonzero fraction gives exactly (f/2^F) × 2^(−14), as a normalised float32.
- R4: A packed-colour channel with exponent 0 and fraction 0 gives +0.0 (00000000h).
- R5: A packed-colour channel with exponent 31 and fraction 0 gives +infinity (7F800000h).
- R6: A packed-colour channel with exponent 31 and a nonzero fraction gives the quiet NaN 7FC00000h.
- R7: With `in_mode` = 1 (shared exponent), e is taken from bits 31:27, the blue fraction from 26:18, green from 17:9 and red from 8:0. Each channel gives exactly (f/512) × 2^(e−15).
- R8: In shared-exponent mode, a channel whose fraction is 0 gives +0.0 whatever the exponent is.
- R9: No output float ever has its sign bit (bit 31) set.
- R10: Outputs change exactly one clock after a word is accepted, and `out_valid` follows `in_valid` with one cycle of delay. While `in_valid` is low the channel outputs hold their values.
- R11: After reset, `out_valid` and all three channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is offered this cycle |
| in_mode | input | 1 | 0 = packed colour, 1 = shared exponent |
| in_word | input | 32 | Packed pixel word |
| out_valid | output | 1 | Channel outputs carry a new result |
| out_red | output | 32 | Red channel, float32 |
| out_green | output | 32 | Green channel, float32 |
| out_blue | output | 32 | Blue channel, float32 |

## Verification
Some properties are checked on every cycle. These are the one-cycle valid delay, holding the outputs while idle, the cleared sign bit, and the special encodings: infinity and NaN from an all-ones exponent, and +0.0 from a zero shared-exponent fraction. The numeric value of normal and denormal channels, the placement of each channel's bits in both layouts, and the normalisation through the leading-zero count are shown only by the bench's sweeps. Those sweeps cover every 11-bit and 10-bit code and every combination of shared exponent and fraction, and the bench compares each result against a value it computes in real arithmetic.

// File: rtl/pkfu_pkg.sv
package pkfu_pkg;
  localparam int F32_W       = 32;
  localparam int F32_MANT_W  = 23;
  localparam int F32_EXP_W   = 8;
  localparam int F32_BIAS    = 127;
  localparam int SMALL_EXP_W = 5;
  localparam int SMALL_BIAS  = 15;
  localparam logic [F32_W-1:0] F32_POS_INF = 32'h7F80_0000;
  localparam logic [F32_W-1:0] F32_QNAN    = 32'h7FC0_0000;
  localparam logic [F32_W-1:0] F32_ZERO    = 32'h0000_0000;

  typedef enum logic {
    MODE_PACKED = 1'b0,
    MODE_SHARED = 1'b1
  } unpack_mode_e;

  // Positive float32 from an already biased exponent and a mantissa
  function automatic logic [F32_W-1:0] f32_pos(input logic [F32_EXP_W-1:0] bexp,
                                               input logic [F32_MANT_W-1:0] mant);
    return {1'b0, bexp, mant};
  endfunction
endpackage

// File: rtl/pkfu_lzc.sv
module pkfu_lzc #(
  parameter int W = 6,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/pkfu_small_cvt.sv
module pkfu_small_cvt
  import pkfu_pkg::*;
#(
  parameter int FRAC_W = 6,
  localparam int CODE_W = SMALL_EXP_W + FRAC_W,
  localparam int LZ_W   = $clog2(FRAC_W + 1),
  localparam int PAD_W  = F32_MANT_W - FRAC_W,
  // float32 biased exponent of 2^0 for a small exponent of 0 offset: 127 - 15
  localparam int NORM_OFS = F32_BIAS - SMALL_BIAS
) (
  input  logic [CODE_W-1:0] code,
  output logic [F32_W-1:0]  f32
);
  logic [SMALL_EXP_W-1:0] e;
  logic [FRAC_W-1:0]      f;
  logic [LZ_W-1:0]        lz;
  logic [FRAC_W-1:0]      f_norm;
  logic                   exp_max, exp_min, frac_nz;

  assign e = code[CODE_W-1 -: SMALL_EXP_W];
  assign f = code[FRAC_W-1:0];

  pkfu_lzc #(.W(FRAC_W)) u_lzc (.val(f), .count(lz));

  // Drop the leading one; the remainder becomes the float32 fraction
  assign f_norm  = f << (lz + 1'b1);
  assign exp_max = &e;
  assign exp_min = ~|e;
  assign frac_nz = |f;

  always_comb begin
    if (exp_max) begin
      f32 = frac_nz ? F32_QNAN : F32_POS_INF;
    end else if (!exp_min) begin
      f32 = f32_pos(F32_EXP_W'(e) + F32_EXP_W'(NORM_OFS), {f, {PAD_W{1'b0}}});
    end else if (frac_nz) begin
      // value 2^(-14) * 0.f: biased exponent = 112 - lz
      f32 = f32_pos(F32_EXP_W'(NORM_OFS) - F32_EXP_W'(lz), {f_norm, {PAD_W{1'b0}}});
    end else begin
      f32 = F32_ZERO;
    end
  end
endmodule

// File: rtl/pkfu_shared_cvt.sv
module pkfu_shared_cvt
  import pkfu_pkg::*;
#(
  parameter int MANT_W = 9,
  localparam int LZ_W  = $clog2(MANT_W + 1),
  localparam int PAD_W = F32_MANT_W - MANT_W,
  // value f * 2^(e - 15 - MANT_W), msb at MANT_W-1-lz: biased = e + 111 - lz
  localparam int SH_OFS = F32_BIAS - SMALL_BIAS - 1
) (
  input  logic [SMALL_EXP_W-1:0] sexp,
  input  logic [MANT_W-1:0]      frac,
  output logic [F32_W-1:0]       f32
);
  logic [LZ_W-1:0]   lz;
  logic [MANT_W-1:0] f_norm;

  pkfu_lzc #(.W(MANT_W)) u_lzc (.val(frac), .count(lz));

  assign f_norm = frac << (lz + 1'b1);

  always_comb begin
    if (|frac) begin
      f32 = f32_pos(F32_EXP_W'(sexp) + F32_EXP_W'(SH_OFS) - F32_EXP_W'(lz),
                    {f_norm, {PAD_W{1'b0}}});
    end else begin
      f32 = F32_ZERO;
    end
  end
endmodule

// File: rtl/pkfloat_unpack.sv
module pkfloat_unpack
  import pkfu_pkg::*;
#(
  parameter int WIDE_FRAC_W   = 6,
  parameter int NARROW_FRAC_W = 5,
  parameter int SHARED_MANT_W = 9,
  localparam int NCH     = 3,
  localparam int WIDE_W  = SMALL_EXP_W + WIDE_FRAC_W,
  localparam int WORD_W  = 2 * WIDE_W + SMALL_EXP_W + NARROW_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [F32_W-1:0]  out_red,
  output logic [F32_W-1:0]  out_green,
  output logic [F32_W-1:0]  out_blue
);
  logic [F32_W-1:0] packed_f [NCH];
  logic [F32_W-1:0] shared_f [NCH];
  logic [F32_W-1:0] sel_f    [NCH];
  unpack_mode_e     mode;

  assign mode = unpack_mode_e'(in_mode);

  // Packed colour: channel 0 = red (low), 2 = blue (narrow, top)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_packed
    localparam int FW   = (ch == NCH - 1) ? NARROW_FRAC_W : WIDE_FRAC_W;
    localparam int BASE = ch * WIDE_W;
    pkfu_small_cvt #(.FRAC_W(FW)) u_cvt (
      .code (in_word[BASE +: SMALL_EXP_W + FW]),
      .f32  (packed_f[ch])
    );
  end

  // Shared exponent: fractions from red (low) upward, exponent on top
  for (genvar ch = 0; ch < NCH; ch++) begin : g_shared
    pkfu_shared_cvt #(.MANT_W(SHARED_MANT_W)) u_cvt (
      .sexp (in_word[WORD_W-1 -: SMALL_EXP_W]),
      .frac (in_word[ch*SHARED_MANT_W +: SHARED_MANT_W]),
      .f32  (shared_f[ch])
    );
  end

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      sel_f[ch] = (mode == MODE_SHARED) ? shared_f[ch] : packed_f[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_red   <= F32_ZERO;
      out_green <= F32_ZERO;
      out_blue  <= F32_ZERO;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_red   <= sel_f[0];
        out_green <= sel_f[1];
        out_blue  <= sel_f[2];
      end
    end
  end
endmodule

// File: rtl/pkfu_unpack_chk.sv
module pkfu_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_mode,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [31:0] out_red,
  input logic [31:0] out_green,
  input logic [31:0] out_blue
);
  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_red) && $stable(out_green) && $stable(out_blue)));
  p_sign_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_red[31] && !out_green[31] && !out_blue[31]));
  p_red_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode && in_word[10:6] == 5'h1F && in_word[5:0] == 6'h0)
    |=> out_red == 32'h7F80_0000);
  p_blue_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode && in_word[31:27] == 5'h1F && in_word[26:22] != 5'h0)
    |=> out_blue == 32'h7FC0_0000);
  p_green_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode && in_word[21:11] == 11'h0) |=> out_green == 32'h0);
  p_shared_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode && in_word[8:0] == 9'h0) |=> out_red == 32'h0);
  p_reset_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && out_red == 32'h0));
endmodule

bind pkfloat_unpack pkfu_unpack_chk u_chk (.*);

// File: tb/tb_pkfloat_unpack.sv
module tb_pkfloat_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [31:0] in_word = 32'h0;
  logic        out_valid;
  logic [31:0] out_red, out_green, out_blue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pkfloat_unpack dut (.*);

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  // Exact positive real -> float32 bits via the double encoding
  function automatic logic [31:0] to_f32(input real v);
    logic [63:0] d;
    int de;
    if (v == 0.0) return 32'h0;
    d  = $realtobits(v);
    de = int'(d[62:52]) - 1023 + 127;
    return {1'b0, de[7:0], d[51:29]};
  endfunction

  function automatic logic [31:0] small_ref(input int e, input int f, input int fw);
    if (e == 31) return (f != 0) ? 32'h7FC0_0000 : 32'h7F80_0000;
    if (e == 0) return to_f32(real'(f) * pow2(-14 - fw));
    return to_f32(real'((1 << fw) + f) * pow2(e - 15 - fw));
  endfunction

  function automatic string small_tag(input int e, input int f);
    if (e == 31) return (f != 0) ? "R6" : "R5";
    if (e == 0) return (f != 0) ? "R3" : "R4";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic mode, input logic [31:0] word);
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = mode;
    in_word  = word;
    @(posedge clk);
    #1;
  endtask

  int sign_seen = 0;

  initial begin
    logic [31:0] hr, hg, hb;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 valid", {31'h0, out_valid}, 32'h0);
    chk("R11 red", out_red, 32'h0);
    chk("R11 blue", out_blue, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 layout with R2..R6 values: every 11-bit code in red/green, every 10-bit in blue
    for (int i = 0; i < 2048; i++) begin
      int e11 = (i >> 6) & 31, f11 = i & 63;
      int e10 = (i >> 5) & 31, f10 = i & 31;
      logic [31:0] w = {i[9:0], i[10:0], i[10:0]};
      apply(1'b0, w);
      chk({"R10 valid"}, {31'h0, out_valid}, 32'h1);
      chk({"R1 red ", small_tag(e11, f11)}, out_red, small_ref(e11, f11, 6));
      chk({"R1 green ", small_tag(e11, f11)}, out_green, small_ref(e11, f11, 6));
      chk({"R1 blue ", small_tag(e10, f10)}, out_blue, small_ref(e10, f10, 5));
      sign_seen += out_red[31] + out_green[31] + out_blue[31];
    end

    // R2 largest finite values
    apply(1'b0, {5'd30, 5'd31, 5'd30, 6'd63, 5'd30, 6'd63});
    chk("R2 max red", out_red, to_f32(65024.0));
    chk("R2 max blue", out_blue, to_f32(64512.0));

    // R7/R8 shared exponent: every exponent with every fraction
    for (int e = 0; e < 32; e++) begin
      for (int f = 0; f < 512; f++) begin
        int fg = f ^ 9'h155;
        int fb = (f * 3 + 7) & 511;
        logic [31:0] w;
        w = {e[4:0], fb[8:0], fg[8:0], f[8:0]};
        apply(1'b1, w);
        chk((f == 0) ? "R8 red" : "R7 red", out_red, to_f32(real'(f) * pow2(e - 24)));
        chk((fg == 0) ? "R8 green" : "R7 green", out_green, to_f32(real'(fg) * pow2(e - 24)));
        chk((fb == 0) ? "R8 blue" : "R7 blue", out_blue, to_f32(real'(fb) * pow2(e - 24)));
        sign_seen += out_red[31] + out_green[31] + out_blue[31];
      end
    end

    // R9: no sign bit seen anywhere in the sweeps
    chk("R9", sign_seen, 0);

    // R10: idle cycle holds outputs and drops valid
    apply(1'b0, 32'h3C1E_0F07);
    hr = out_red; hg = out_green; hb = out_blue;
    @(negedge clk);
    in_valid = 1'b0;
    in_mode  = 1'b1;
    in_word  = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    chk("R10 idle valid", {31'h0, out_valid}, 32'h0);
    chk("R10 hold red", out_red, hr);
    chk("R10 hold green", out_green, hg);
    chk("R10 hold blue", out_blue, hb);
    @(posedge clk);
    #1;
    chk("R10 hold red 2", out_red, hr);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule